// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block collects eight interrupt request lines, remembers each rising request until it is served, and presents one interrupt signal to the processor. When several requests wait at once, a fixed order decides between them. The processor answers with an acknowledge pulse. The controller then places an 8-bit vector on its data output for one cycle. The vector is a programmable 5-bit base joined to the 3-bit number of the winning line.

An in-service register records the lines now being handled. While a line is in service, only a line of strictly higher priority can raise the interrupt again, so handlers nest. An end-of-interrupt pulse retires the highest-priority line in service.

Two copies can work as a pair. The slave's interrupt output drives master input 2. When the master acknowledges line 2, it flags the cascade select and keeps its own data output quiet, and the slave answers with its own vector. The pair offers 15 usable request lines.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o, data_oe_o and cas_sel_o are low, no request is pending and no line is in service.
- R2: A 0-to-1 transition on irq_i[k], sampled at a clock edge, records a pending request for line k. int_o rises right after that edge if the line is eligible. A level that stays high does not record the request again.
- R3: Among eligible pending lines, the lowest line number wins; line 0 has the highest priority.
- R4: An acknowledge (inta_i high at an edge while int_o is high) drives data_o = {base, line number} with data_oe_o high for exactly the next cycle. Bits 7:3 are the base and bits 2:0 are the line.
- R5: An acknowledge marks the winning line as in service and clears its pending request.
- R6: While line k is in service, pending lines numbered k or higher do not raise int_o, and a line numbered below k does.
- R7: An eoi_i pulse clears only the lowest-numbered in-service line, which is the highest priority one. Requests it was blocking may then raise int_o.
- R8: A line whose bit is set in the mask loaded by cfg_we_i still records requests but does not raise int_o. Clearing the mask bit lets it raise int_o.
- R9: In master role (role_i = 2'b01), when line 2 is the winner, cas_sel_o is high. Its acknowledge marks line 2 in service but leaves data_oe_o low, and the slave drives the vector instead.
- R10: In slave role (role_i = 2'b10), an acknowledge while cas_sel_i is low is ignored, and the slave's pending request and int_o are kept.
- R11: inta_i while int_o is low produces no vector and changes no state.
- R12: A master/slave pair serves 15 lines: the 7 master lines other than 2, and all 8 slave lines, each with its own vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| role_i | input | 2 | 00 single, 01 master, 10 slave |
| cfg_we_i | input | 1 | Load the base and the mask |
| cfg_base_i | input | 5 | Vector base |
| cfg_mask_i | input | 8 | Per-line mask, 1 = masked |
| irq_i | input | 8 | Request lines, rising edge recorded |
| inta_i | input | 1 | Processor acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| cas_sel_i | input | 1 | Slave: master selects this chip for the vector |
| int_o | output | 1 | Interrupt to processor or to master line 2 |
| cas_sel_o | output | 1 | Master: the cascade line is the current winner |
| data_o | output | 8 | Vector |
| data_oe_o | output | 1 | Vector valid, one cycle after acknowledge |

## Verification
Some rules are checked by assertions on every cycle. A vector appears only one cycle after an acknowledge. An acknowledge with no interrupt, a slave acknowledge without select, or a master acknowledge of the cascade line never yields a vector. int_o always has an unmasked pending line behind it and never rises while line 0 is in service. An accepted acknowledge always leaves a line in service.

Other behaviour shows only in the bench's scenarios, which compare every vector on both chips against a queue of expected vectors. These include the priority order, nesting and its unwinding by end-of-interrupt, masking and unmasking, and the two-chip hand-off over all 15 lines.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'b00,
    ROLE_MASTER = 2'b01,
    ROLE_SLAVE  = 2'b10
  } irq_role_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Lowest set index wins.
module irq_prio_pick #(
  parameter int N_LINES = 8,
  localparam int IDW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_i,
  output logic               valid_o,
  output logic [IDW-1:0]     id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] irr_o
);
  logic [N_LINES-1:0] irq_q;
  logic [N_LINES-1:0] rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      irr_o <= '0;
    end else begin
      irq_q <= irq_i;
      irr_o <= (irr_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N_LINES = 8,
  localparam int IDW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_i,
  input  logic [IDW-1:0]     set_id_i,
  input  logic               eoi_i,
  output logic [N_LINES-1:0] isr_o,
  output logic               top_valid_o,
  output logic [IDW-1:0]     top_id_o
);
  logic [N_LINES-1:0] set_vec;
  logic [N_LINES-1:0] clr_vec;

  irq_prio_pick #(.N_LINES(N_LINES)) i_top (
    .req_i   (isr_o),
    .valid_o (top_valid_o),
    .id_o    (top_id_o)
  );

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (set_i) set_vec[set_id_i] = 1'b1;
    if (eoi_i && top_valid_o) clr_vec[top_id_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int CAS_LINE = 2,
  localparam int IDW    = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IDW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         role_i,
  input  logic               cfg_we_i,
  input  logic [BASE_W-1:0]  cfg_base_i,
  input  logic [N_LINES-1:0] cfg_mask_i,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               inta_i,
  input  logic               eoi_i,
  input  logic               cas_sel_i,
  output logic               int_o,
  output logic               cas_sel_o,
  output logic [VEC_W-1:0]   data_o,
  output logic               data_oe_o
);
  irq_role_e          role;
  logic [BASE_W-1:0]  base_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] irr;
  logic [N_LINES-1:0] isr;
  logic [N_LINES-1:0] eligible;
  logic [N_LINES-1:0] ack_clr;
  logic               win_valid;
  logic [IDW-1:0]     win_id;
  logic               top_valid;
  logic [IDW-1:0]     top_id;
  logic               win_is_cas;
  logic               ack_take;
  logic               ack_drive;

  assign role = irq_role_e'(role_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      base_q <= cfg_base_i;
      mask_q <= cfg_mask_i;
    end
  end

  irq_req_latch #(.N_LINES(N_LINES)) i_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .clr_i  (ack_clr),
    .irr_o  (irr)
  );

  assign eligible = irr & ~mask_q;

  irq_prio_pick #(.N_LINES(N_LINES)) i_win (
    .req_i   (eligible),
    .valid_o (win_valid),
    .id_o    (win_id)
  );

  irq_inservice #(.N_LINES(N_LINES)) i_isr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (ack_take),
    .set_id_i    (win_id),
    .eoi_i       (eoi_i),
    .isr_o       (isr),
    .top_valid_o (top_valid),
    .top_id_o    (top_id)
  );

  // Preempt only strictly above the highest line in service.
  assign int_o      = win_valid && (!top_valid || (win_id < top_id));
  assign win_is_cas = (role == ROLE_MASTER) && (win_id == IDW'(CAS_LINE));
  assign cas_sel_o  = int_o && win_is_cas;
  assign ack_take   = inta_i && int_o && ((role != ROLE_SLAVE) || cas_sel_i);
  assign ack_drive  = ack_take && !win_is_cas;

  always_comb begin
    ack_clr = '0;
    if (ack_take) ack_clr[win_id] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      data_oe_o <= ack_drive;
      if (ack_drive) data_o <= {base_q, win_id};
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int N_LINES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         role_i,
  input logic               inta_i,
  input logic               eoi_i,
  input logic               cas_sel_i,
  input logic               int_o,
  input logic               cas_sel_o,
  input logic               data_oe_o,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] isr,
  input logic [N_LINES-1:0] mask_q
);
  a_r4_vector_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(inta_i));

  a_r11_idle_ack_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> !data_oe_o);

  a_r9_master_quiet_on_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == 2'b01 && cas_sel_o && inta_i) |=> !data_oe_o);

  a_r10_slave_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == 2'b10 && inta_i && !cas_sel_i) |=> !data_oe_o);

  a_r8_int_has_unmasked_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~mask_q) != '0));

  a_r6_no_int_over_line0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !isr[0]);

  a_r5_ack_marks_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !eoi_i && (role_i != 2'b10 || cas_sel_i)) |=> (isr != '0));
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.N_LINES(N_LINES)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .role_i    (role_i),
  .inta_i    (inta_i),
  .eoi_i     (eoi_i),
  .cas_sel_i (cas_sel_i),
  .int_o     (int_o),
  .cas_sel_o (cas_sel_o),
  .data_oe_o (data_oe_o),
  .irr       (irr),
  .isr       (isr),
  .mask_q    (mask_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam logic [4:0] M_BASE = 5'h0A;
  localparam logic [4:0] S_BASE = 5'h10;

  typedef struct {
    logic       src;
    logic [7:0] vec;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inta = 1'b0;
  logic       eoi_m = 1'b0, eoi_s = 1'b0;
  logic       we_m = 1'b0, we_s = 1'b0;
  logic [4:0] base_cfg = '0;
  logic [7:0] mask_cfg = '0;
  logic [7:0] m_irq = '0, s_irq = '0;
  logic       m_int, m_cas, m_oe, s_int, s_cas, s_oe;
  logic [7:0] m_data, s_data;
  logic [7:0] m_irq_in;

  int n_tests = 0, n_fail = 0, oe_seen = 0;
  bit done = 1'b0;
  sb_item_t sb[$];

  always #2 clk = ~clk;

  assign m_irq_in = {m_irq[7:3], s_int, m_irq[1:0]};

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .role_i(2'b01),
    .cfg_we_i(we_m), .cfg_base_i(base_cfg), .cfg_mask_i(mask_cfg),
    .irq_i(m_irq_in), .inta_i(inta), .eoi_i(eoi_m), .cas_sel_i(1'b0),
    .int_o(m_int), .cas_sel_o(m_cas), .data_o(m_data), .data_oe_o(m_oe)
  );

  prio_irq_ctrl i_prio_irq_ctrl_slv (
    .clk_i(clk), .rst_ni(rst_n), .role_i(2'b10),
    .cfg_we_i(we_s), .cfg_base_i(base_cfg), .cfg_mask_i(mask_cfg),
    .irq_i(s_irq), .inta_i(inta), .eoi_i(eoi_s), .cas_sel_i(m_cas),
    .int_o(s_int), .cas_sel_o(s_cas), .data_o(s_data), .data_oe_o(s_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input bit slave, input logic [4:0] b, input logic [7:0] m);
    base_cfg = b; mask_cfg = m;
    we_m = !slave; we_s = slave;
    tick();
    we_m = 1'b0; we_s = 1'b0;
  endtask

  task automatic ack(input bit expect_vec, input logic src, input logic [7:0] vec,
                     input string tag);
    sb_item_t it;
    if (expect_vec) begin
      it.src = src; it.vec = vec; it.tag = tag;
      sb.push_back(it);
    end
    inta = 1'b1;
    tick();
    inta = 1'b0;
    tick();
  endtask

  task automatic eoi(input bit m, input bit s);
    eoi_m = m; eoi_s = s;
    tick();
    eoi_m = 1'b0; eoi_s = 1'b0;
    tick();
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (m_oe && s_oe) chk(1'b0, "R9 both chips drive", 1, 0);
      if (m_oe || s_oe) begin
        sb_item_t e;
        logic [8:0] got;
        oe_seen++;
        got = m_oe ? {1'b0, m_data} : {1'b1, s_data};
        if (sb.size() == 0) begin
          chk(1'b0, "R11 unexpected vector", int'(got), 0);
        end else begin
          e = sb.pop_front();
          chk(got == {e.src, e.vec}, e.tag, int'(got), int'({e.src, e.vec}));
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int seen;
    tick(3);
    // R1
    chk(m_int == 1'b0 && s_int == 1'b0, "R1 int after reset", int'(m_int), 0);
    chk(m_oe == 1'b0 && s_oe == 1'b0 && m_cas == 1'b0, "R1 oe/cas after reset",
        int'(m_oe), 0);
    rst_n = 1'b1;
    tick();
    cfg(1'b0, M_BASE, 8'h00);
    cfg(1'b1, S_BASE, 8'h00);

    // R2, R4, R5
    m_irq[5] = 1'b1;
    tick();
    chk(m_int == 1'b1, "R2 edge raises int", int'(m_int), 1);
    ack(1'b1, 1'b0, {M_BASE, 3'd5}, "R4 vector line 5");
    chk(m_int == 1'b0, "R5 level held does not rerequest", int'(m_int), 0);
    m_irq[5] = 1'b0;
    eoi(1'b1, 1'b0);

    // R3, R6, R7
    m_irq[6] = 1'b1; m_irq[3] = 1'b1;
    tick();
    ack(1'b1, 1'b0, {M_BASE, 3'd3}, "R3 lowest line wins");
    chk(m_int == 1'b0, "R6 line 6 blocked by line 3", int'(m_int), 0);
    m_irq[1] = 1'b1;
    tick();
    chk(m_int == 1'b1, "R6 line 1 preempts line 3", int'(m_int), 1);
    ack(1'b1, 1'b0, {M_BASE, 3'd1}, "R6 nested vector");
    eoi(1'b1, 1'b0);
    chk(m_int == 1'b0, "R7 eoi cleared line 1 only", int'(m_int), 0);
    eoi(1'b1, 1'b0);
    chk(m_int == 1'b1, "R7 eoi of line 3 unblocks 6", int'(m_int), 1);
    ack(1'b1, 1'b0, {M_BASE, 3'd6}, "R7 deferred vector");
    eoi(1'b1, 1'b0);
    m_irq = '0;
    tick();

    // R8
    cfg(1'b0, M_BASE, 8'h10);
    m_irq[4] = 1'b1;
    tick();
    chk(m_int == 1'b0, "R8 masked line silent", int'(m_int), 0);
    cfg(1'b0, M_BASE, 8'h00);
    chk(m_int == 1'b1, "R8 unmask raises int", int'(m_int), 1);
    ack(1'b1, 1'b0, {M_BASE, 3'd4}, "R8 vector after unmask");
    m_irq[4] = 1'b0;
    eoi(1'b1, 1'b0);

    // R11
    seen = oe_seen;
    ack(1'b0, 1'b0, 8'h00, "");
    chk(oe_seen == seen, "R11 idle ack no vector", oe_seen - seen, 0);
    chk(m_int == 1'b0 && s_int == 1'b0, "R11 idle ack state", int'(m_int), 0);

    // R9
    s_irq[6] = 1'b1;
    tick(3);
    chk(m_cas == 1'b1, "R9 cascade select", int'(m_cas), 1);
    ack(1'b1, 1'b1, {S_BASE, 3'd6}, "R9 slave vector");
    s_irq[6] = 1'b0;
    eoi(1'b1, 1'b1);

    // R10
    s_irq[0] = 1'b1; m_irq[0] = 1'b1;
    tick(3);
    chk(m_cas == 1'b0, "R10 master line 0 beats cascade", int'(m_cas), 0);
    ack(1'b1, 1'b0, {M_BASE, 3'd0}, "R10 master vector, slave quiet");
    chk(s_int == 1'b1, "R10 slave kept its request", int'(s_int), 1);
    m_irq[0] = 1'b0;
    eoi(1'b1, 1'b0);
    chk(m_cas == 1'b1, "R10 cascade pending after eoi", int'(m_cas), 1);
    ack(1'b1, 1'b1, {S_BASE, 3'd0}, "R10 slave vector later");
    s_irq[0] = 1'b0;
    eoi(1'b1, 1'b1);

    // R12
    for (int l = 0; l < 8; l++) begin
      if (l != 2) begin
        m_irq[l] = 1'b1;
        tick();
        ack(1'b1, 1'b0, {M_BASE, 3'(l)}, "R12 master line");
        m_irq[l] = 1'b0;
        eoi(1'b1, 1'b0);
      end
    end
    for (int l = 0; l < 8; l++) begin
      s_irq[l] = 1'b1;
      tick(3);
      ack(1'b1, 1'b1, {S_BASE, 3'(l)}, "R12 slave line");
      s_irq[l] = 1'b0;
      eoi(1'b1, 1'b1);
    end

    tick(3);
    chk(sb.size() == 0, "R4 all expected vectors seen", sb.size(), 0);
    finish_run();
  end
endmodule